// File: doc/BRIEF.md
# Selectable Video Output Formatter

This block turns a pixel-rate stream of processed video into an 8-bit byte stream for an external video module. It has one clock, the byte clock. Inputs carry one pixel every second clock, so each pixel becomes exactly two output bytes. The inputs are luma and both chroma samples, 5:6:5 red/green/blue, a raw sensor sample, horizontal and vertical sync, and a data-valid flag. All of these are captured on alternate cycles, starting with the first clock after reset. A two-bit format select picks one of four encodings: YCbCr 4:2:2 with embedded timing codes, plain YCbCr 4:2:2, packed 16-bit RGB, or raw samples. Control bits set the luma/chroma byte order, the Cb/Cr start order and the red/blue swap. Two further bits invert the sync outputs.

Every pixel passes through a three-stage pixel pipeline. The two pixels of lookahead let the block place the start-of-active-video code before the first active pixel without stalling the stream. The format and ordering controls are sampled only when a rising vertical sync reaches the output stage. A frame is therefore always sent in a single format. The sync inversion bits act at once.

Top module: `vidfmt_out`

## Requirements
- R1: Each pixel is captured on every second clock edge, with the first capture at the first edge after reset. The first byte of pixel k is on `dout_o` after edge 2k+5 and its second byte after edge 2k+6, where edges are counted from 0.
- R2: In both YCbCr formats (select 00 and 01), `luma_first_i`=1 sends luma then chroma for each pixel, and 0 sends chroma then luma. Together with R3, this gives the orders Y Cb Y Cr, Y Cr Y Cb, Cb Y Cr Y and Cr Y Cb Y.
- R3: Chroma alternates between the pixels of one valid run. The first valid pixel of each run carries Cb when `cb_first_i`=1 and Cr when it is 0, and the next pixel carries the other one.
- R4: Format 10 sends {R[4:0],G[5:3]} and then {G[2:0],B[4:0]}. With `rb_swap_i`=1 it sends {B[4:0],G[5:3]} and then {G[2:0],R[4:0]}.
- R5: Format 11 sends the raw sample as the high bits D[9:8], padded with six zero bits above them, and then D[7:0].
- R6: In format 00, the two pixel slots before each valid run carry FF 00 00 XY with H=0. The two pixel slots after the run carry FF 00 00 XY with H=1. Runs must be at least four pixels apart.
- R7: The XY byte is, from bit 7 down: 1, F, V, H, V^H, F^H, F^V, F^V^H. V is the vertical sync level of that slot. F toggles at every vertical sync rise and starts at 0 after reset.
- R8: In YCbCr formats, a blank slot sends 10h in the luma position and 80h in the chroma position. Format 01 never sends timing codes. The RGB and raw formats send 00h while blank.
- R9: `hs_o` and `vs_o` carry the sync of the pixel whose bytes are currently on `dout_o`. Each one is XORed with its inversion bit as sampled at the same edge.
- R10: The format, ordering and swap controls take effect only from the pixel that holds a vertical sync rise. Changes at any other time do not alter the frame in progress.
- R11: During reset `dout_o`, `hs_o` and `vs_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock, twice the pixel rate |
| rst_n | input | 1 | Asynchronous reset, active low |
| y_i | input | 8 | Luma sample |
| cb_i | input | 8 | Blue-difference sample |
| cr_i | input | 8 | Red-difference sample |
| r_i | input | 5 | Red field |
| g_i | input | 6 | Green field |
| b_i | input | 5 | Blue field |
| raw_i | input | RAW_W | Raw sensor sample |
| hs_i | input | 1 | Horizontal sync in |
| vs_i | input | 1 | Vertical sync in, high during vertical blank |
| de_i | input | 1 | Pixel valid (active video) |
| fmt_sel_i | input | 2 | 00 YCbCr+codes, 01 YCbCr, 10 RGB, 11 raw |
| luma_first_i | input | 1 | Luma byte before chroma byte |
| cb_first_i | input | 1 | First pixel of a run carries Cb |
| rb_swap_i | input | 1 | Swap red and blue fields in RGB |
| hs_inv_i | input | 1 | Invert horizontal sync output |
| vs_inv_i | input | 1 | Invert vertical sync output |
| dout_o | output | 8 | Output byte |
| hs_o | output | 1 | Horizontal sync out |
| vs_o | output | 1 | Vertical sync out |

## Verification
The hardest case to reach is a control change in the middle of a frame. The new settings must not appear until the next vertical sync rise has reached the output stage, two pixels after it enters. The bench drives a two-frame stream and switches the format from YCbCr to RGB partway through the first frame. It then compares every byte of both frames against a per-pixel model that latches the controls only at the sync rise. The same two-frame stream also drives the field bit through a toggle, which the XY protection bits must follow.

// File: rtl/vidfmt_pkg.sv
package vidfmt_pkg;

   typedef enum logic [1:0] {
      FMT_656 = 2'b00,
      FMT_601 = 2'b01,
      FMT_RGB = 2'b10,
      FMT_RAW = 2'b11
   } fmt_e;

   typedef struct packed {
      fmt_e fmt;
      logic luma_first;
      logic cb_first;
      logic rb_swap;
   } cfg_t;

   typedef enum logic [2:0] {
      SL_DATA,
      SL_BLANK,
      SL_SAV_A,
      SL_SAV_B,
      SL_EAV_A,
      SL_EAV_B
   } slot_e;

   // pixel slots taken by each timing reference code
   localparam int TRS_PIX = 2;

   function automatic logic [7:0] trs_xy(input logic f, input logic v, input logic h);
      return {1'b1, f, v, h, v ^ h, f ^ h, f ^ v, f ^ v ^ h};
   endfunction

endpackage

// File: rtl/vidfmt_pipe.sv
module vidfmt_pipe
   import vidfmt_pkg::*;
#(
   parameter int RAW_W = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [7:0]       y_i,
   input  logic [7:0]       cb_i,
   input  logic [7:0]       cr_i,
   input  logic [4:0]       r_i,
   input  logic [5:0]       g_i,
   input  logic [4:0]       b_i,
   input  logic [RAW_W-1:0] raw_i,
   input  logic             hs_i,
   input  logic             vs_i,
   input  logic             de_i,
   input  cfg_t             cfg_i,
   output logic             ph_o,
   output logic [7:0]       y_o,
   output logic [7:0]       cb_o,
   output logic [7:0]       cr_o,
   output logic [4:0]       r_o,
   output logic [5:0]       g_o,
   output logic [4:0]       b_o,
   output logic [RAW_W-1:0] raw_o,
   output logic             hs_o,
   output logic             vs_o,
   output logic             vs_nx_o,
   output logic [2*TRS_PIX:0] de_hist_o,
   output cfg_t             cfg_o,
   output logic             par_o,
   output logic             fld_o
);

   // data stages: lookahead plus the output stage
   localparam int NSTG = TRS_PIX + 1;
   // valid history: lookahead, output stage, trailing slots
   localparam int NDE  = 2 * TRS_PIX + 1;
   localparam int OUTS = NSTG - 1;

   typedef struct packed {
      logic [7:0]       y;
      logic [7:0]       cb;
      logic [7:0]       cr;
      logic [4:0]       r;
      logic [5:0]       g;
      logic [4:0]       b;
      logic [RAW_W-1:0] raw;
      logic             hs;
      logic             vs;
   } pix_t;

   pix_t             stg [NSTG];
   logic [NDE-1:0]   de_q;
   logic             ph;
   cfg_t             cfg_q;
   logic             par_q;
   logic             fld_q;
   logic             shift;
   logic             vs_rise;

   assign shift   = ~ph;
   assign vs_rise = stg[OUTS-1].vs & ~stg[OUTS].vs;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ph <= 1'b0;
      else        ph <= ~ph;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stg[0] <= '0;
      end else if (shift) begin
         stg[0].y   <= y_i;
         stg[0].cb  <= cb_i;
         stg[0].cr  <= cr_i;
         stg[0].r   <= r_i;
         stg[0].g   <= g_i;
         stg[0].b   <= b_i;
         stg[0].raw <= raw_i;
         stg[0].hs  <= hs_i;
         stg[0].vs  <= vs_i;
      end
   end

   genvar gi;
   generate
      for (gi = 1; gi < NSTG; gi++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     stg[gi] <= '0;
            else if (shift) stg[gi] <= stg[gi-1];
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     de_q <= '0;
      else if (shift) de_q <= {de_q[NDE-2:0], de_i};
   end

   // chroma parity of the pixel entering the output stage
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         par_q <= 1'b0;
      end else if (shift) begin
         if (de_q[OUTS-1] && de_q[OUTS]) par_q <= ~par_q;
         else                            par_q <= 1'b0;
      end
   end

   // controls and field flag move only with a vertical sync rise
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q <= '0;
         fld_q <= 1'b0;
      end else if (shift && vs_rise) begin
         cfg_q <= cfg_i;
         fld_q <= ~fld_q;
      end
   end

   assign ph_o      = ph;
   assign y_o       = stg[OUTS].y;
   assign cb_o      = stg[OUTS].cb;
   assign cr_o      = stg[OUTS].cr;
   assign r_o       = stg[OUTS].r;
   assign g_o       = stg[OUTS].g;
   assign b_o       = stg[OUTS].b;
   assign raw_o     = stg[OUTS].raw;
   assign hs_o      = stg[OUTS].hs;
   assign vs_o      = stg[OUTS].vs;
   assign vs_nx_o   = stg[OUTS-1].vs;
   assign de_hist_o = de_q;
   assign cfg_o     = cfg_q;
   assign par_o     = par_q;
   assign fld_o     = fld_q;

endmodule

// File: rtl/vidfmt_slot.sv
module vidfmt_slot
   import vidfmt_pkg::*;
(
   input  logic [2*TRS_PIX:0] de_hist_i,
   input  fmt_e               fmt_i,
   output slot_e              slot_o
);

   // bit TRS_PIX is the output stage; lower bits are newer pixels
   localparam int OUTB = TRS_PIX;

   logic cur, nx1, nx2, pv1, pv2;

   assign nx2 = de_hist_i[OUTB-2];
   assign nx1 = de_hist_i[OUTB-1];
   assign cur = de_hist_i[OUTB];
   assign pv1 = de_hist_i[OUTB+1];
   assign pv2 = de_hist_i[OUTB+2];

   always_comb begin
      if (cur) begin
         slot_o = SL_DATA;
      end else if (fmt_i != FMT_656) begin
         slot_o = SL_BLANK;
      end else if (nx1) begin
         slot_o = SL_SAV_B;
      end else if (nx2) begin
         slot_o = SL_SAV_A;
      end else if (pv1) begin
         slot_o = SL_EAV_A;
      end else if (pv2) begin
         slot_o = SL_EAV_B;
      end else begin
         slot_o = SL_BLANK;
      end
   end

endmodule

// File: rtl/vidfmt_pack.sv
module vidfmt_pack
   import vidfmt_pkg::*;
#(
   parameter int          RAW_W   = 10,
   parameter logic [7:0]  BLANK_Y = 8'h10,
   parameter logic [7:0]  BLANK_C = 8'h80
) (
   input  slot_e            slot_i,
   input  cfg_t             cfg_i,
   input  logic             par_i,
   input  logic             fld_i,
   input  logic             vs_i,
   input  logic             second_i,
   input  logic [7:0]       y_i,
   input  logic [7:0]       cb_i,
   input  logic [7:0]       cr_i,
   input  logic [4:0]       r_i,
   input  logic [5:0]       g_i,
   input  logic [4:0]       b_i,
   input  logic [RAW_W-1:0] raw_i,
   output logic [7:0]       dout_o
);

   localparam int HI_W = RAW_W - 8;

   logic [7:0] raw_hi;
   logic       is_luma;
   logic       use_cr;
   logic       ycc;
   logic [7:0] chroma;
   logic [4:0] rgb_hi;
   logic [4:0] rgb_lo;

   generate
      if (HI_W == 8) begin : g_raw_full
         assign raw_hi = raw_i[RAW_W-1:8];
      end else begin : g_raw_pad
         assign raw_hi = {{(8 - HI_W){1'b0}}, raw_i[RAW_W-1:8]};
      end
   endgenerate

   assign is_luma = second_i ^ cfg_i.luma_first;
   assign use_cr  = par_i ^ ~cfg_i.cb_first;
   assign chroma  = use_cr ? cr_i : cb_i;
   assign rgb_hi  = cfg_i.rb_swap ? b_i : r_i;
   assign rgb_lo  = cfg_i.rb_swap ? r_i : b_i;
   assign ycc     = (cfg_i.fmt == FMT_656) || (cfg_i.fmt == FMT_601);

   always_comb begin
      dout_o = 8'h00;
      case (slot_i)
         SL_DATA: begin
            case (cfg_i.fmt)
               FMT_656, FMT_601: dout_o = is_luma ? y_i : chroma;
               FMT_RGB:          dout_o = second_i ? {g_i[2:0], rgb_lo}
                                                   : {rgb_hi, g_i[5:3]};
               default:          dout_o = second_i ? raw_i[7:0] : raw_hi;
            endcase
         end
         SL_BLANK: dout_o = ycc ? (is_luma ? BLANK_Y : BLANK_C) : 8'h00;
         SL_SAV_A, SL_EAV_A: dout_o = second_i ? 8'h00 : 8'hFF;
         SL_SAV_B: dout_o = second_i ? trs_xy(fld_i, vs_i, 1'b0) : 8'h00;
         SL_EAV_B: dout_o = second_i ? trs_xy(fld_i, vs_i, 1'b1) : 8'h00;
         default:  dout_o = 8'h00;
      endcase
   end

endmodule

// File: rtl/vidfmt_out.sv
module vidfmt_out
   import vidfmt_pkg::*;
#(
   parameter int          RAW_W   = 10,
   parameter logic [7:0]  BLANK_Y = 8'h10,
   parameter logic [7:0]  BLANK_C = 8'h80
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [7:0]       y_i,
   input  logic [7:0]       cb_i,
   input  logic [7:0]       cr_i,
   input  logic [4:0]       r_i,
   input  logic [5:0]       g_i,
   input  logic [4:0]       b_i,
   input  logic [RAW_W-1:0] raw_i,
   input  logic             hs_i,
   input  logic             vs_i,
   input  logic             de_i,
   input  logic [1:0]       fmt_sel_i,
   input  logic             luma_first_i,
   input  logic             cb_first_i,
   input  logic             rb_swap_i,
   input  logic             hs_inv_i,
   input  logic             vs_inv_i,
   output logic [7:0]       dout_o,
   output logic             hs_o,
   output logic             vs_o
);

   generate
      if (RAW_W < 9 || RAW_W > 16) begin : g_bad_raw
         $error("vidfmt_out: RAW_W must lie in 9..16 to fill two bytes");
      end
      if (TRS_PIX != 2) begin : g_bad_trs
         $error("vidfmt_out: timing codes need exactly two pixel slots");
      end
   endgenerate

   cfg_t                 cfg_in;
   cfg_t                 cfg_q;
   logic                 ph;
   logic [7:0]           s_y, s_cb, s_cr;
   logic [4:0]           s_r, s_b;
   logic [5:0]           s_g;
   logic [RAW_W-1:0]     s_raw;
   logic                 s_hs, vs_s2, vs_s1;
   logic [2*TRS_PIX:0]   de_hist;
   logic                 par, fld;
   slot_e                slot;
   logic [7:0]           dout_nx;

   assign cfg_in.fmt        = fmt_e'(fmt_sel_i);
   assign cfg_in.luma_first = luma_first_i;
   assign cfg_in.cb_first   = cb_first_i;
   assign cfg_in.rb_swap    = rb_swap_i;

   vidfmt_pipe #(.RAW_W(RAW_W)) u_pipe (
      .clk       (clk),
      .rst_n     (rst_n),
      .y_i       (y_i),
      .cb_i      (cb_i),
      .cr_i      (cr_i),
      .r_i       (r_i),
      .g_i       (g_i),
      .b_i       (b_i),
      .raw_i     (raw_i),
      .hs_i      (hs_i),
      .vs_i      (vs_i),
      .de_i      (de_i),
      .cfg_i     (cfg_in),
      .ph_o      (ph),
      .y_o       (s_y),
      .cb_o      (s_cb),
      .cr_o      (s_cr),
      .r_o       (s_r),
      .g_o       (s_g),
      .b_o       (s_b),
      .raw_o     (s_raw),
      .hs_o      (s_hs),
      .vs_o      (vs_s2),
      .vs_nx_o   (vs_s1),
      .de_hist_o (de_hist),
      .cfg_o     (cfg_q),
      .par_o     (par),
      .fld_o     (fld)
   );

   vidfmt_slot u_slot (
      .de_hist_i (de_hist),
      .fmt_i     (cfg_q.fmt),
      .slot_o    (slot)
   );

   vidfmt_pack #(
      .RAW_W   (RAW_W),
      .BLANK_Y (BLANK_Y),
      .BLANK_C (BLANK_C)
   ) u_pack (
      .slot_i   (slot),
      .cfg_i    (cfg_q),
      .par_i    (par),
      .fld_i    (fld),
      .vs_i     (vs_s2),
      .second_i (~ph),
      .y_i      (s_y),
      .cb_i     (s_cb),
      .cr_i     (s_cr),
      .r_i      (s_r),
      .g_i      (s_g),
      .b_i      (s_b),
      .raw_i    (s_raw),
      .dout_o   (dout_nx)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dout_o <= 8'h00;
         hs_o   <= 1'b0;
         vs_o   <= 1'b0;
      end else begin
         dout_o <= dout_nx;
         hs_o   <= s_hs ^ hs_inv_i;
         vs_o   <= vs_s2 ^ vs_inv_i;
      end
   end

endmodule

// File: rtl/vidfmt_chk.sv
module vidfmt_chk
   import vidfmt_pkg::*;
#(
   parameter int RAW_W = 10
) (
   input logic       clk,
   input logic       rst_n,
   input logic       ph,
   input slot_e      slot,
   input cfg_t       cfg_q,
   input logic       vs_s1,
   input logic       vs_s2,
   input logic [7:0] dout_o
);

   AST_SAV_SEQ: assert property (@(posedge clk) disable iff (!rst_n)
      (slot == SL_SAV_A && !ph) |=> (slot == SL_SAV_B)); // R6

   AST_EAV_SEQ: assert property (@(posedge clk) disable iff (!rst_n)
      (slot == SL_EAV_A && !ph) |=> (slot == SL_EAV_B)); // R6

   AST_TRS_LEAD: assert property (@(posedge clk) disable iff (!rst_n)
      ((slot == SL_SAV_A || slot == SL_EAV_A) && ph) |=> (dout_o == 8'hFF)); // R6

   AST_XY_PROT: assert property (@(posedge clk) disable iff (!rst_n)
      ((slot == SL_SAV_B || slot == SL_EAV_B) && !ph) |=>
      (dout_o[7] && dout_o[3] == (dout_o[5] ^ dout_o[4])
                 && dout_o[2] == (dout_o[6] ^ dout_o[4])
                 && dout_o[1] == (dout_o[6] ^ dout_o[5])
                 && dout_o[0] == (dout_o[6] ^ dout_o[5] ^ dout_o[4]))); // R7

   AST_XY_SAV_H: assert property (@(posedge clk) disable iff (!rst_n)
      (slot == SL_SAV_B && !ph) |=> !dout_o[4]); // R7

   AST_XY_EAV_H: assert property (@(posedge clk) disable iff (!rst_n)
      (slot == SL_EAV_B && !ph) |=> dout_o[4]); // R7

   AST_RAW_PAD: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_q.fmt == FMT_RAW && slot == SL_DATA && ph) |=>
      ((dout_o >> (RAW_W - 8)) == 8'h00)); // R5

   AST_NO_CODE: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_q.fmt != FMT_656) |-> (slot == SL_DATA || slot == SL_BLANK)); // R8

   AST_CFG_AT_VS: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_q != $past(cfg_q)) |-> ($past(vs_s1) && !$past(vs_s2) && !$past(ph))); // R10

endmodule

bind vidfmt_out vidfmt_chk #(.RAW_W(RAW_W)) u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .ph     (ph),
   .slot   (slot),
   .cfg_q  (cfg_q),
   .vs_s1  (vs_s1),
   .vs_s2  (vs_s2),
   .dout_o (dout_o)
);

// File: tb/vidfmt_out_tb.sv
module vidfmt_out_tb;

   localparam int CLK_PERIOD = 10;
   localparam int RAW_W      = 10;
   localparam int MAXP       = 64;
   localparam int MAXN       = 2 * MAXP + 16;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic [7:0]       y_i, cb_i, cr_i;
   logic [4:0]       r_i, b_i;
   logic [5:0]       g_i;
   logic [RAW_W-1:0] raw_i;
   logic             hs_i, vs_i, de_i;
   logic [1:0]       fmt_sel_i;
   logic             luma_first_i, cb_first_i, rb_swap_i, hs_inv_i, vs_inv_i;
   logic [7:0]       dout_o;
   logic             hs_o, vs_o;

   always #(CLK_PERIOD / 2) clk = ~clk;

   vidfmt_out #(.RAW_W(RAW_W)) u_dut (
      .clk          (clk),
      .rst_n        (rst_n),
      .y_i          (y_i),
      .cb_i         (cb_i),
      .cr_i         (cr_i),
      .r_i          (r_i),
      .g_i          (g_i),
      .b_i          (b_i),
      .raw_i        (raw_i),
      .hs_i         (hs_i),
      .vs_i         (vs_i),
      .de_i         (de_i),
      .fmt_sel_i    (fmt_sel_i),
      .luma_first_i (luma_first_i),
      .cb_first_i   (cb_first_i),
      .rb_swap_i    (rb_swap_i),
      .hs_inv_i     (hs_inv_i),
      .vs_inv_i     (vs_inv_i),
      .dout_o       (dout_o),
      .hs_o         (hs_o),
      .vs_o         (vs_o)
   );

   int total = 0;
   int bad   = 0;

   // stimulus per pixel
   logic [7:0]       a_y [MAXP], a_cb [MAXP], a_cr [MAXP];
   logic [4:0]       a_r [MAXP], a_b [MAXP];
   logic [5:0]       a_g [MAXP];
   logic [RAW_W-1:0] a_raw [MAXP];
   logic             a_hs [MAXP], a_vs [MAXP], a_de [MAXP];
   logic [1:0]       a_fmt [MAXP];
   logic             a_lf [MAXP], a_cbf [MAXP], a_swp [MAXP], a_hinv [MAXP], a_vinv [MAXP];
   // model state per output pixel
   logic [1:0]       m_fmt [MAXP];
   logic             m_lf [MAXP], m_cbf [MAXP], m_swp [MAXP], m_par [MAXP], m_fld [MAXP];
   // observations per edge
   logic [7:0]       o_dat [MAXN];
   logic             o_hs [MAXN], o_vs [MAXN];

   initial begin
      #(CLK_PERIOD * 150000);
      total++;
      bad++;
      $display("FAIL R1 watchdog expired: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   task automatic check8(input string tag, input string what, input logic [7:0] act,
                         input logic [7:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s: actual=%02h expected=%02h", tag, what, act, exp);
      end
   endtask

   task automatic gen(input int np, input int fr2);
      for (int i = 0; i < MAXP; i++) begin
         logic inr;
         inr      = (i < np);
         a_vs[i]  = inr && ((i < 2) || (fr2 > 0 && i >= fr2 && i < fr2 + 2));
         a_de[i]  = inr && ((i >= 4 && i < 14) || (i >= 20 && i < 30) ||
                            (fr2 > 0 && i >= fr2 + 4 && i < fr2 + 10));
         a_hs[i]  = inr && ((i >= 15 && i < 19) || (i >= 31 && i < 34));
         a_y[i]   = 8'(32 + 3 * i);
         a_cb[i]  = 8'(64 + i);
         a_cr[i]  = 8'(192 - 5 * i);
         a_r[i]   = 5'(i) ^ 5'h15;
         a_g[i]   = 6'(7 * i + 3);
         a_b[i]   = ~5'(i);
         a_raw[i] = RAW_W'(37 * i + 341);
      end
   endtask

   task automatic set_cfg(input int from, input logic [1:0] fmt, input logic lf,
                          input logic cbf, input logic swp, input logic hinv,
                          input logic vinv);
      for (int i = from; i < MAXP; i++) begin
         a_fmt[i] = fmt; a_lf[i] = lf; a_cbf[i] = cbf; a_swp[i] = swp;
         a_hinv[i] = hinv; a_vinv[i] = vinv;
      end
   endtask

   task automatic drive(input int m);
      y_i = a_y[m]; cb_i = a_cb[m]; cr_i = a_cr[m];
      r_i = a_r[m]; g_i = a_g[m]; b_i = a_b[m]; raw_i = a_raw[m];
      hs_i = a_hs[m]; vs_i = a_vs[m]; de_i = a_de[m];
      fmt_sel_i = a_fmt[m]; luma_first_i = a_lf[m]; cb_first_i = a_cbf[m];
      rb_swap_i = a_swp[m]; hs_inv_i = a_hinv[m]; vs_inv_i = a_vinv[m];
   endtask

   function automatic logic de_at(input int i);
      if (i < 0 || i >= MAXP) return 1'b0;
      return a_de[i];
   endfunction

   function automatic logic [7:0] xy(input logic f, input logic v, input logic h);
      return {1'b1, f, v, h, v ^ h, f ^ h, f ^ v, f ^ v ^ h};
   endfunction

   // expected byte of output pixel j, from the requirements
   function automatic logic [7:0] exp_byte(input int j, input logic sec);
      logic       luma, cr;
      logic [4:0] hi, lo;
      logic       ycc;
      luma = sec ^ m_lf[j];
      cr   = m_par[j] ^ ~m_cbf[j];
      ycc  = (m_fmt[j] == 2'b00) || (m_fmt[j] == 2'b01);
      hi   = m_swp[j] ? a_b[j] : a_r[j];
      lo   = m_swp[j] ? a_r[j] : a_b[j];
      if (de_at(j)) begin
         case (m_fmt[j])
            2'b10:   return sec ? {a_g[j][2:0], lo} : {hi, a_g[j][5:3]};
            2'b11:   return sec ? a_raw[j][7:0] : 8'(a_raw[j] >> 8);
            default: return luma ? a_y[j] : (cr ? a_cr[j] : a_cb[j]);
         endcase
      end
      if (m_fmt[j] == 2'b00) begin
         if (de_at(j + 1))      return sec ? xy(m_fld[j], a_vs[j], 1'b0) : 8'h00;
         else if (de_at(j + 2)) return sec ? 8'h00 : 8'hFF;
         else if (de_at(j - 1)) return sec ? 8'h00 : 8'hFF;
         else if (de_at(j - 2)) return sec ? xy(m_fld[j], a_vs[j], 1'b1) : 8'h00;
      end
      if (ycc) return luma ? 8'h10 : 8'h80;
      return 8'h00;
   endfunction

   task automatic build_model(input int np);
      logic [1:0] cf;
      logic       clf, ccb, csw, f, p;
      cf = 2'b00; clf = 1'b0; ccb = 1'b0; csw = 1'b0; f = 1'b0; p = 1'b0;
      for (int j = 0; j < np; j++) begin
         logic vprev;
         vprev = (j > 0) ? a_vs[j-1] : 1'b0;
         if (a_vs[j] && !vprev) begin
            cf = a_fmt[j+2]; clf = a_lf[j+2]; ccb = a_cbf[j+2]; csw = a_swp[j+2];
            f = ~f;
         end
         p = (a_de[j] && j > 0 && a_de[j-1]) ? ~p : 1'b0;
         m_fmt[j] = cf; m_lf[j] = clf; m_cbf[j] = ccb; m_swp[j] = csw;
         m_par[j] = p; m_fld[j] = f;
      end
   endtask

   task automatic run(input int np, input string tag);
      rst_n = 1'b0;
      drive(0);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      for (int n = 0; n < 2 * np + 8; n++) begin
         if (n % 2 == 0) drive(n / 2);
         @(posedge clk);
         @(negedge clk);
         o_dat[n] = dout_o;
         o_hs[n]  = hs_o;
         o_vs[n]  = vs_o;
      end
      build_model(np);
      for (int n = 5; n <= 2 * np + 4; n++) begin
         int   k;
         logic sec;
         k   = (n - 5) / 2;
         sec = logic'((n - 5) % 2);
         check8(tag, $sformatf("byte edge %0d", n), o_dat[n], exp_byte(k, sec));
         check8("R9", $sformatf("hs edge %0d", n), {7'd0, o_hs[n]},
                {7'd0, a_hs[k] ^ a_hinv[n/2]});
         check8("R9", $sformatf("vs edge %0d", n), {7'd0, o_vs[n]},
                {7'd0, a_vs[k] ^ a_vinv[n/2]});
      end
   endtask

   task automatic t_reset;
      gen(40, 0);
      set_cfg(0, 2'b00, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1);
      drive(0);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      check8("R11", "reset dout", dout_o, 8'h00);
      check8("R11", "reset hs", {7'd0, hs_o}, 8'h00);
      check8("R11", "reset vs", {7'd0, vs_o}, 8'h00);
   endtask

   task automatic t_ycc_orders;
      for (int o = 0; o < 4; o++) begin
         gen(40, 0);
         set_cfg(0, 2'b01, logic'(o[0]), logic'(o[1]), 1'b0, 1'b0, 1'b0);
         run(40, "R1 R2 R3 R8");
      end
   endtask

   task automatic t_656;
      gen(52, 36);
      set_cfg(0, 2'b00, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
      run(52, "R6 R7 R8");
      gen(52, 36);
      set_cfg(0, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
      run(52, "R2 R6 R7");
   endtask

   task automatic t_rgb;
      gen(40, 0);
      set_cfg(0, 2'b10, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
      run(40, "R4");
      gen(40, 0);
      set_cfg(0, 2'b10, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
      run(40, "R4 swap");
   endtask

   task automatic t_raw;
      gen(40, 0);
      set_cfg(0, 2'b11, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
      run(40, "R5");
   endtask

   task automatic t_cfg_midframe;
      gen(52, 36);
      set_cfg(0, 2'b01, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
      set_cfg(10, 2'b10, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
      run(52, "R10");
   endtask

   task automatic t_sync_inv;
      gen(40, 0);
      set_cfg(0, 2'b11, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
      set_cfg(8, 2'b11, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
      set_cfg(20, 2'b11, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1);
      run(40, "R9 R5");
   endtask

   initial begin
      t_reset();
      t_ycc_orders();
      t_656();
      t_rgb();
      t_raw();
      t_cfg_midframe();
      t_sync_inv();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule